// File: doc/BRIEF.md
# Instruction Class Decoder with Datapath Control

This block is the main control unit of a small single-cycle 32-bit processor. It supports a reduced instruction set: word load, word store, add-immediate, branch-if-equal, jump-and-link, and the register-register add/and/or group. It takes the 7-bit major opcode field of the instruction now being executed.

It works in two purely combinational stages. The first stage tests a handful of distinguishing opcode bits with plain gates and raises exactly one instruction-class flag. The second stage forms the five datapath steering signals by OR-ing those flags.

A strict-decode option is on by default. It screens out every opcode outside the supported subset, so an unknown instruction writes neither a register nor memory. With the option off, the sparse gate decode runs unguarded.

No clock or state is involved. Both stages settle in the same cycle as the opcode they respond to.

Top module: `main_ctl`

## Requirements
- R1: Opcode 0000011 (load) raises is_load, reg_we, alu_imm, mem_rd and wb_from_mem, and every other output is 0.
- R2: Opcode 0010011 (add-immediate) raises is_imm, reg_we and alu_imm, and every other output is 0.
- R3: Opcode 0100011 (store) raises is_store, alu_imm and mem_wr, and every other output is 0.
- R4: Opcode 0110011 (register-register) raises is_reg and reg_we, and every other output is 0.
- R5: Opcode 1100011 (branch-if-equal) raises is_branch only.
- R6: Opcode 1101111 (jump-and-link) raises is_jump only.
- R7: At most one of the six class flags is 1 for any opcode.
- R8: Any opcode whose two lowest bits (bits 1:0) are not both 1 drives all eleven outputs to 0.
- R9: Any opcode with bits 1:0 equal to 11 whose bits 6:2 match none of the six supported patterns drives all eleven outputs to 0.
- R10: mem_rd and mem_wr are never both 1, and reg_we is never 1 together with mem_wr.
- R11: The outputs are a combinational function of opcode. They reflect a new opcode in the same cycle it is applied, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Major opcode field of the current instruction |
| is_load | output | 1 | Word-load class flag |
| is_store | output | 1 | Word-store class flag |
| is_imm | output | 1 | Register-immediate arithmetic class flag |
| is_reg | output | 1 | Register-register arithmetic class flag |
| is_branch | output | 1 | Branch-if-equal class flag |
| is_jump | output | 1 | Jump-and-link class flag |
| reg_we | output | 1 | Register file write enable |
| alu_imm | output | 1 | ALU second operand taken from the immediate |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | Write-back value taken from memory rather than ALU |

## Verification
The class flags and the datapath controls derived from them settle in the same cycle. A class flag and a control produced by the wrong OR term can therefore appear together at one sample. The bench changes the opcode on every cycle, switching between legal, illegal-low-bit and unsupported-pattern opcodes with no idle cycle in between. In each cycle it compares all eleven outputs as one vector against an independent opcode table. Any stale flag or misrouted control from the previous opcode therefore shows as a mismatch in that very cycle.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W   = 7;
    localparam int FLAG_N = 6;
    localparam int CTRL_N = 5;

    localparam logic [OP_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OP_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OP_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OP_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OP_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OP_W-1:0] OPC_JUMP   = 7'b1101111;

    typedef struct packed {
        logic ld;
        logic st;
        logic imm;
        logic rr;
        logic br;
        logic jmp;
    } class_flags_t;

    typedef struct packed {
        logic reg_we;
        logic alu_imm;
        logic mem_rd;
        logic mem_wr;
        logic wb_mem;
    } dp_ctrl_t;

endpackage

// File: rtl/ctl_class_decode.sv
module ctl_class_decode
    import ctl_pkg::*;
#(
    parameter bit STRICT = 1'b1
) (
    input  logic [OP_W-1:0] opcode,
    output class_flags_t    flags
);

    logic b6, b5, b4, b3, b2;
    class_flags_t sparse;
    logic low_ok, grp_alu_mem, pat_br, pat_jmp, legal;

    assign b6 = opcode[6];
    assign b5 = opcode[5];
    assign b4 = opcode[4];
    assign b3 = opcode[3];
    assign b2 = opcode[2];

    // Sparse decode on the distinguishing upper bits only
    assign sparse.jmp = b3;
    assign sparse.ld  = ~(b6 | b5 | b4 | b3 | b2);
    assign sparse.st  = b5 & ~b4 & ~b6;
    assign sparse.imm = b4 & ~b5;
    assign sparse.rr  = b5 & b4;
    assign sparse.br  = b6 & b5 & ~b3;

    // Legality screen: low bits 11 and one of the supported upper patterns
    assign low_ok      = opcode[1] & opcode[0];
    assign grp_alu_mem = ~b6 & ~b3 & ~b2;
    assign pat_br      = b6 & b5 & ~b4 & ~b3 & ~b2;
    assign pat_jmp     = b6 & b5 & ~b4 & b3 & b2;
    assign legal       = low_ok & (grp_alu_mem | pat_br | pat_jmp);

    generate
        if (STRICT) begin : g_strict
            assign flags = sparse & {FLAG_N{legal}};

            always_comb begin
                if (!$isunknown(opcode)) begin
                    // R7
                    flags_onehot_chk: assert ($onehot0(flags));
                    // R8
                    lowbits_quiet_chk: assert (low_ok || (flags == '0));
                end
            end
        end else begin : g_sparse
            assign flags = sparse;
        end
    endgenerate

endmodule

// File: rtl/ctl_dp_form.sv
module ctl_dp_form
    import ctl_pkg::*;
(
    input  class_flags_t flags,
    output dp_ctrl_t     ctrl
);

    assign ctrl.reg_we  = flags.rr | flags.imm | flags.ld;
    assign ctrl.alu_imm = flags.imm | flags.ld | flags.st;
    assign ctrl.mem_rd  = flags.ld;
    assign ctrl.mem_wr  = flags.st;
    assign ctrl.wb_mem  = flags.ld;

    always_comb begin
        if (!$isunknown(flags) && $onehot0(flags)) begin
            // R10
            mem_excl_chk: assert (!(ctrl.mem_rd && ctrl.mem_wr));
            // R10
            store_no_regwr_chk: assert (!(ctrl.reg_we && ctrl.mem_wr));
        end
    end

endmodule

// File: rtl/main_ctl.sv
module main_ctl
    import ctl_pkg::*;
#(
    parameter bit STRICT = 1'b1
) (
    input  logic [6:0] opcode,
    output logic       is_load,
    output logic       is_store,
    output logic       is_imm,
    output logic       is_reg,
    output logic       is_branch,
    output logic       is_jump,
    output logic       reg_we,
    output logic       alu_imm,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       wb_from_mem
);

    class_flags_t flags;
    dp_ctrl_t     ctrl;

    ctl_class_decode #(.STRICT(STRICT)) u_decode (
        .opcode (opcode),
        .flags  (flags)
    );

    ctl_dp_form u_form (
        .flags (flags),
        .ctrl  (ctrl)
    );

    assign is_load     = flags.ld;
    assign is_store    = flags.st;
    assign is_imm      = flags.imm;
    assign is_reg      = flags.rr;
    assign is_branch   = flags.br;
    assign is_jump     = flags.jmp;
    assign reg_we      = ctrl.reg_we;
    assign alu_imm     = ctrl.alu_imm;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign wb_from_mem = ctrl.wb_mem;

    always_comb begin
        if (!$isunknown(opcode)) begin
            // R9
            ctrl_needs_class_chk: assert ((ctrl == '0) || (flags != '0));
        end
    end

endmodule

// File: tb/test_main_ctl.sv
module test_main_ctl;

    logic       clk;
    logic [6:0] opcode;
    logic is_load, is_store, is_imm, is_reg, is_branch, is_jump;
    logic reg_we, alu_imm, mem_rd, mem_wr, wb_from_mem;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    main_ctl i_main_ctl (
        .opcode      (opcode),
        .is_load     (is_load),
        .is_store    (is_store),
        .is_imm      (is_imm),
        .is_reg      (is_reg),
        .is_branch   (is_branch),
        .is_jump     (is_jump),
        .reg_we      (reg_we),
        .alu_imm     (alu_imm),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .wb_from_mem (wb_from_mem)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Order: load store imm reg branch jump | reg_we alu_imm mem_rd mem_wr wb
    function automatic logic [10:0] expect_of(input logic [6:0] op);
        case (op)
            7'b0000011: return 11'b100000_11101; // R1
            7'b0010011: return 11'b001000_11000; // R2
            7'b0100011: return 11'b010000_01010; // R3
            7'b0110011: return 11'b000100_10000; // R4
            7'b1100011: return 11'b000010_00000; // R5
            7'b1101111: return 11'b000001_00000; // R6
            default:    return 11'b000000_00000; // R8 / R9
        endcase
    endfunction

    function automatic string req_of(input logic [6:0] op);
        case (op)
            7'b0000011: return "R1";
            7'b0010011: return "R2";
            7'b0100011: return "R3";
            7'b0110011: return "R4";
            7'b1100011: return "R5";
            7'b1101111: return "R6";
            default:    return (op[1:0] != 2'b11) ? "R8" : "R9";
        endcase
    endfunction

    function automatic logic [10:0] observed();
        return {is_load, is_store, is_imm, is_reg, is_branch, is_jump,
                reg_we, alu_imm, mem_rd, mem_wr, wb_from_mem};
    endfunction

    // Opcode applied at negedge, sampled 2 ns later in the same cycle (R11)
    task automatic apply_and_check(input logic [6:0] op);
        logic [10:0] got;
        logic [10:0] exp;
        @(negedge clk);
        opcode = op;
        #2;
        got = observed();
        exp = expect_of(op);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s/R11 op=%b got=%b exp=%b", req_of(op), op, got, exp);
        end
        total++;
        if ($countones(got[10:5]) > 1) begin
            bad++;
            $display("FAIL R7 op=%b flags=%b exp=onehot0", op, got[10:5]);
        end
        total++;
        if ((got[2] && got[1]) || (got[4] && got[1])) begin
            bad++;
            $display("FAIL R10 op=%b ctrl=%b exp=no rd+wr, no we+wr", op, got[4:0]);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        opcode = 7'b0000000;
        // R8 initial zero opcode
        apply_and_check(7'b0000000);
        // Directed corners: R1..R6 back to back, then neighbours
        apply_and_check(7'b0000011);
        apply_and_check(7'b0010011);
        apply_and_check(7'b0100011);
        apply_and_check(7'b0110011);
        apply_and_check(7'b1100011);
        apply_and_check(7'b1101111);
        apply_and_check(7'b1100011); // R5 after R6
        apply_and_check(7'b1101101); // R8 jump with bad low bits
        apply_and_check(7'b0000010); // R8
        apply_and_check(7'b1100111); // R9 near-branch
        apply_and_check(7'b0001111); // R9
        apply_and_check(7'b1111111); // R9
        // Exhaustive sweep of every opcode
        for (int k = 0; k < 128; k++) apply_and_check(7'(k));
        // Constrained random: half legal, half arbitrary
        for (int n = 0; n < 1500; n++) begin
            logic [6:0] op;
            if ($urandom_range(1, 0) == 0) begin
                case ($urandom_range(5, 0))
                    0: op = 7'b0000011;
                    1: op = 7'b0010011;
                    2: op = 7'b0100011;
                    3: op = 7'b0110011;
                    4: op = 7'b1100011;
                    default: op = 7'b1101111;
                endcase
            end else begin
                op = 7'($urandom);
            end
            apply_and_check(op);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule